// File: doc/BRIEF.md
# Amplitude-Pulse Minute Frame Decoder

The block decodes a time signal that is broadcast as one-minute frames of amplitude pulses. At the start of every second the carrier drops for a short or a long interval. A short drop means binary zero and a long drop means binary one. In the last second of each minute the carrier does not drop at all, and that silence is the only mark that a new minute has begun. The block receives a debounced level that is high while the carrier is reduced, plus a one-cycle millisecond tick. It measures the width of each drop and the spacing between drop starts, and it collects the classified bits into a frame.

When a gap shows that a minute has ended, the block checks the frame it has collected. The frame must hold exactly 59 bits, every pulse must have a legal width, the start bit must be one, and three even-parity groups must hold. If all of this is true, the block loads its BCD time and date outputs and its five status flags, and it raises `fresh` for one cycle. A frame that fails any check leaves the outputs at their previous values. All widths and the gap limit are parameters counted in ticks. The defaults assume a 1 ms tick.

Top module: `minute_frame_decoder`

## Requirements
- R1: After a synchronous active-low reset, every time, date and flag output is zero and `fresh` is low.
- R2: A reduced-carrier pulse lasting from ZERO_MIN to ZERO_MAX ticks inclusive (defaults 60 and 140) is taken as a 0 bit.
- R3: A pulse lasting from ONE_MIN to ONE_MAX ticks inclusive (defaults 160 and 250) is taken as a 1 bit.
- R4: Any pulse whose width falls outside both ranges marks the current frame as bad, and a bad frame is rejected.
- R5: When more than GAP_LIM ticks (default 1500) pass between two pulse starts, that pulse start ends the current frame and the frame is evaluated. A spacing of one normal second never ends a frame.
- R6: Frame bit 20 is the start bit. A frame with a 0 in bit 20 is rejected.
- R7: Three parity groups must each have even parity, counting their parity bit: bits 21..28, bits 29..35, and bits 36..58. A frame that fails any group is rejected.
- R8: A frame is accepted only if exactly 59 bits, numbered 0..58, were received before the minute boundary.
- R9: Fields are taken from these bit positions, LSB first: minute from 21..27 (7 bits), hour from 29..34 (6), day of month from 36..41 (6), weekday from 42..44 (3), month from 45..49 (5), year from 50..57 (8). `flags[4:0]` comes from bits 19..15, so `flags[0]` is bit 15 (reserve antenna in use), `flags[1]` is bit 16 (summer-time change coming), `flags[2]` is bit 17 (summer time), `flags[3]` is bit 18 (standard time), and `flags[4]` is bit 19 (leap second coming).
- R10: The outputs change only when a frame is accepted. `fresh` pulses high for exactly one cycle per accepted frame. A rejected frame leaves every output unchanged.
- R11: The pulse whose start ends a frame is also bit 0 of the next frame, so frames sent back to back are each decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms | input | 1 | One-cycle timing tick (1 ms by default) |
| carrier_low | input | 1 | High while the carrier is reduced; must already be synchronous and debounced |
| minute_bcd | output | 7 | Minute in BCD |
| hour_bcd | output | 6 | Hour in BCD |
| mday_bcd | output | 6 | Day of month in BCD |
| wday | output | 3 | Weekday code |
| month_bcd | output | 5 | Month in BCD |
| year_bcd | output | 8 | Year within the century in BCD |
| flags | output | 5 | Status flags from bits 15..19 |
| fresh | output | 1 | One-cycle pulse when the outputs are loaded |

## Verification
Ending one frame and starting the next happen on the same clock edge. The rising edge that shows a long gap triggers the check of the finished frame, and it also begins bit 0 of the next frame. The bench provokes this by sending frames back to back with no idle time between them.

For each frame, the bench checks the outputs in the next frame's second 0. A frame is judged correct only if the previous frame's fields appear or stay as expected, and if the new frame later decodes in turn. That second condition shows its first bit was not lost when the store was cleared.

// File: rtl/mfd_pkg.sv
// Shared constants and the decoded-field record for the minute frame decoder.
// Bit positions are fixed by the broadcast frame layout.
package mfd_pkg;
    localparam int FRAME_BITS = 59;
    localparam int KEEP_LO    = 15;   // lowest frame bit that any check or field uses
    localparam int START_POS  = 20;
    localparam int MIN_LO     = 21;
    localparam int P1_POS     = 28;
    localparam int HOUR_LO    = 29;
    localparam int P2_POS     = 35;
    localparam int DAY_LO     = 36;
    localparam int WDAY_LO    = 42;
    localparam int MON_LO     = 45;
    localparam int YEAR_LO    = 50;
    localparam int P3_POS     = 58;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);

    typedef struct packed {
        logic [4:0] flags;
        logic [7:0] year;
        logic [4:0] month;
        logic [2:0] wday;
        logic [5:0] mday;
        logic [5:0] hour;
        logic [6:0] minute;
    } tfields_t;
endpackage

// File: rtl/mfd_pulse_timer.sv
// Measures reduced-carrier pulses in ticks.
// On each falling edge it emits a bit event that says whether the pulse was a 0, a 1 or illegal.
// On a pulse start that follows a long gap it emits a minute mark.
// Assumes carrier_low is already synchronous and debounced.
module mfd_pulse_timer #(
    parameter int ZERO_MIN = 60,
    parameter int ZERO_MAX = 140,
    parameter int ONE_MIN  = 160,
    parameter int ONE_MAX  = 250,
    parameter int GAP_LIM  = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic carrier_low,
    output logic bit_evt,
    output logic bit_val,
    output logic bit_bad,
    output logic mark
);
    localparam int WW = $clog2(ONE_MAX + 2);
    localparam int GW = $clog2(GAP_LIM + 2);
    localparam logic [WW-1:0] W_SAT = WW'(ONE_MAX + 1);
    localparam logic [GW-1:0] G_SAT = GW'(GAP_LIM + 1);

    logic          cl_q;
    logic [WW-1:0] width_q;
    logic [GW-1:0] gap_q;
    logic          rise, fall, is_zero, is_one;

    assign rise    = carrier_low & ~cl_q;
    assign fall    = ~carrier_low & cl_q;
    assign is_zero = (width_q >= WW'(ZERO_MIN)) && (width_q <= WW'(ZERO_MAX));
    assign is_one  = (width_q >= WW'(ONE_MIN))  && (width_q <= WW'(ONE_MAX));

    // Purpose: count pulse width and start-to-start spacing, and register the edge events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cl_q    <= 1'b0;
            width_q <= '0;
            gap_q   <= '0;
            bit_evt <= 1'b0;
            bit_val <= 1'b0;
            bit_bad <= 1'b0;
            mark    <= 1'b0;
        end else begin
            cl_q <= carrier_low;
            if (rise)
                width_q <= {{(WW-1){1'b0}}, tick_ms};
            else if (carrier_low && tick_ms && width_q != W_SAT)
                width_q <= width_q + 1'b1;
            if (rise)
                gap_q <= {{(GW-1){1'b0}}, tick_ms};
            else if (tick_ms && gap_q != G_SAT)
                gap_q <= gap_q + 1'b1;
            mark    <= rise && (gap_q > GW'(GAP_LIM));
            bit_evt <= fall;
            bit_val <= is_one;
            bit_bad <= !is_zero && !is_one;
        end
    end

    a_r5_mark_at_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
        mark |-> cl_q);
    a_r11_mark_bit_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mark && bit_evt));
    a_r2_bit_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        bit_evt |-> !cl_q);
endmodule

// File: rtl/mfd_frame_store.sv
// Collects classified bits into the frame by arrival order and counts them.
// The count saturates one past a full frame so that extra bits can be detected.
// Keeps a sticky flag for any illegal pulse width.
// A minute mark clears everything. Bits below KEEP_LO are counted but not stored.
module mfd_frame_store
    import mfd_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bit_evt,
    input  logic                          bit_val,
    input  logic                          bit_bad,
    input  logic                          mark,
    output logic [FRAME_BITS-1:KEEP_LO]   frame,
    output logic [CNT_W-1:0]              count,
    output logic                          bad
);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_BITS + 1);

    // Purpose: store each arriving bit at its position, and restart on a minute mark.
    always_ff @(posedge clk) begin
        if (!rst_n || mark) begin
            frame <= '0;
            count <= '0;
            bad   <= 1'b0;
        end else if (bit_evt) begin
            if (count != CNT_SAT)
                count <= count + 1'b1;
            bad <= bad | bit_bad;
            for (int i = KEEP_LO; i < FRAME_BITS; i++)
                if (count == CNT_W'(i))
                    frame[i] <= bit_val;
        end
    end

    a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_SAT);
    a_r11_clear_on_mark: assert property (@(posedge clk) disable iff (!rst_n)
        mark |=> (count == '0) && !bad);
endmodule

// File: rtl/mfd_frame_check.sv
// Checks a completed frame at the minute mark: the bit count, the width flag, the start bit and the three parities.
// Loads the field registers only when the frame passes every check.
// Assumes the frame, count and bad inputs still hold the finished frame in the cycle mark is high.
module mfd_frame_check
    import mfd_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        mark,
    input  logic [FRAME_BITS-1:KEEP_LO] frame,
    input  logic [CNT_W-1:0]            count,
    input  logic                        bad,
    output tfields_t                    fields,
    output logic                        fresh
);
    logic     ok_c;
    tfields_t next_c;

    // Purpose: combine every validity condition of the finished frame.
    always_comb begin
        ok_c = (count == CNT_W'(FRAME_BITS)) && !bad && frame[START_POS]
             && !(^frame[P1_POS:MIN_LO])
             && !(^frame[P2_POS:HOUR_LO])
             && !(^frame[P3_POS:DAY_LO]);
    end

    // Purpose: slice the frame into the decoded fields.
    always_comb begin
        next_c.flags  = frame[KEEP_LO +: 5];
        next_c.minute = frame[MIN_LO  +: 7];
        next_c.hour   = frame[HOUR_LO +: 6];
        next_c.mday   = frame[DAY_LO  +: 6];
        next_c.wday   = frame[WDAY_LO +: 3];
        next_c.month  = frame[MON_LO  +: 5];
        next_c.year   = frame[YEAR_LO +: 8];
    end

    // Purpose: load the outputs and pulse fresh only for an accepted frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields <= '0;
            fresh  <= 1'b0;
        end else begin
            fresh <= mark && ok_c;
            if (mark && ok_c)
                fields <= next_c;
        end
    end

    a_r10_hold_unless_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fields) |-> fresh);
    a_r10_fresh_after_mark: assert property (@(posedge clk) disable iff (!rst_n)
        fresh |-> $past(mark));
    a_r8_fresh_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        fresh |-> $past(count) == CNT_W'(FRAME_BITS));
    a_r6_fresh_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
        fresh |-> $past(frame[START_POS]));
endmodule

// File: rtl/minute_frame_decoder.sv
// Top level. Connects the pulse timer, the frame store and the frame check.
// Assumes the caller provides a one-cycle tick and a clean carrier-reduced level.
module minute_frame_decoder
    import mfd_pkg::*;
#(
    parameter int ZERO_MIN = 60,
    parameter int ZERO_MAX = 140,
    parameter int ONE_MIN  = 160,
    parameter int ONE_MAX  = 250,
    parameter int GAP_LIM  = 1500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       carrier_low,
    output logic [6:0] minute_bcd,
    output logic [5:0] hour_bcd,
    output logic [5:0] mday_bcd,
    output logic [2:0] wday,
    output logic [4:0] month_bcd,
    output logic [7:0] year_bcd,
    output logic [4:0] flags,
    output logic       fresh
);
    logic                        bit_evt, bit_val, bit_bad, mark;
    logic [FRAME_BITS-1:KEEP_LO] frame;
    logic [CNT_W-1:0]            count;
    logic                        bad;
    tfields_t                    fields;

    mfd_pulse_timer #(
        .ZERO_MIN(ZERO_MIN), .ZERO_MAX(ZERO_MAX),
        .ONE_MIN(ONE_MIN),   .ONE_MAX(ONE_MAX),
        .GAP_LIM(GAP_LIM)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .carrier_low(carrier_low),
        .bit_evt(bit_evt), .bit_val(bit_val), .bit_bad(bit_bad), .mark(mark)
    );

    mfd_frame_store u_store (
        .clk(clk), .rst_n(rst_n), .bit_evt(bit_evt), .bit_val(bit_val),
        .bit_bad(bit_bad), .mark(mark), .frame(frame), .count(count), .bad(bad)
    );

    mfd_frame_check u_check (
        .clk(clk), .rst_n(rst_n), .mark(mark), .frame(frame), .count(count),
        .bad(bad), .fields(fields), .fresh(fresh)
    );

    assign minute_bcd = fields.minute;
    assign hour_bcd   = fields.hour;
    assign mday_bcd   = fields.mday;
    assign wday       = fields.wday;
    assign month_bcd  = fields.month;
    assign year_bcd   = fields.year;
    assign flags      = fields.flags;
endmodule

// File: tb/test_minute_frame_decoder.sv
module test_minute_frame_decoder;
    import mfd_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int Z_MIN = 6, Z_MAX = 14, O_MIN = 16, O_MAX = 25, GAP = 150;
    localparam int SEC_TICKS = 100;

    logic clk = 1'b0, rst_n = 1'b0, tick_ms = 1'b0, carrier_low = 1'b0;
    logic [6:0] minute_bcd; logic [5:0] hour_bcd; logic [5:0] mday_bcd;
    logic [2:0] wday; logic [4:0] month_bcd; logic [7:0] year_bcd;
    logic [4:0] flags; logic fresh;

    int checks = 0, fails = 0, fresh_seen = 0, fresh_exp = 0;
    bit done = 0;
    tfields_t exp_f, pend_f;
    bit pend_acc = 0;
    string pend_tag = "R5";

    always #(CLK_PERIOD/2) clk = ~clk;

    minute_frame_decoder #(.ZERO_MIN(Z_MIN), .ZERO_MAX(Z_MAX), .ONE_MIN(O_MIN),
        .ONE_MAX(O_MAX), .GAP_LIM(GAP)) i_minute_frame_decoder (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .carrier_low(carrier_low),
        .minute_bcd(minute_bcd), .hour_bcd(hour_bcd), .mday_bcd(mday_bcd),
        .wday(wday), .month_bcd(month_bcd), .year_bcd(year_bcd),
        .flags(flags), .fresh(fresh));

    always @(posedge clk) if (rst_n && fresh) fresh_seen++;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic tfields_t rand_fields();
        tfields_t f;
        f.minute = {3'($urandom_range(5)), 4'($urandom_range(9))};
        f.hour   = {2'($urandom_range(2)), 4'($urandom_range(3))};
        f.mday   = {2'($urandom_range(2)), 4'($urandom_range(9))};
        f.wday   = 3'($urandom_range(7, 1));
        f.month  = {1'($urandom_range(1)), 4'($urandom_range(2))};
        f.year   = {4'($urandom_range(9)), 4'($urandom_range(9))};
        f.flags  = 5'($urandom);
        return f;
    endfunction

    // Builds a frame from the requirement R9 positions with even parity (R7) and start bit set (R6).
    function automatic logic [58:0] make_frame(input tfields_t f);
        logic [58:0] b;
        b = 59'($urandom);
        b[15 +: 5] = f.flags;
        b[20]      = 1'b1;
        b[21 +: 7] = f.minute; b[28] = ^f.minute;
        b[29 +: 6] = f.hour;   b[35] = ^f.hour;
        b[36 +: 6] = f.mday;   b[42 +: 3] = f.wday;
        b[45 +: 5] = f.month;  b[50 +: 8] = f.year;
        b[58] = ^b[57:36];
        return b;
    endfunction

    task automatic ms_step(input logic lvl, input int idx);
        @(negedge clk);
        carrier_low = lvl;
        tick_ms = 1'b1;
        if (idx % 8 == 7) begin
            @(negedge clk);
            tick_ms = 1'b0;
        end
    endtask

    task automatic check_prev();
        if (pend_acc) begin
            exp_f = pend_f;
            fresh_exp++;
        end
        chk(minute_bcd == exp_f.minute, {pend_tag, " R9 minute"}, minute_bcd, exp_f.minute);
        chk(hour_bcd   == exp_f.hour,   {pend_tag, " R9 hour"},   hour_bcd,   exp_f.hour);
        chk({mday_bcd, wday, month_bcd, year_bcd} == {exp_f.mday, exp_f.wday, exp_f.month, exp_f.year},
            {pend_tag, " R9 date"}, {mday_bcd, wday, month_bcd, year_bcd},
            {exp_f.mday, exp_f.wday, exp_f.month, exp_f.year});
        chk(flags == exp_f.flags, {pend_tag, " R9 flags"}, flags, exp_f.flags);
        chk(fresh_seen == fresh_exp, {pend_tag, " R10 fresh count"}, fresh_seen, fresh_exp);
    endtask

    // Sends seconds 0..58 (or fewer), then the silent second 59. The check of the previous frame runs during second 0 (R11).
    task automatic send_frame(input logic [58:0] b, input int nbits, input int w0, input int w1,
                              input int bad_sec, input int bad_w, input bit acc,
                              input tfields_t nf, input string tag);
        for (int s = 0; s < 60; s++) begin
            int w;
            w = (s < nbits && s < 59) ? ((s == bad_sec) ? bad_w : (b[s] ? w1 : w0)) : 0;
            for (int m = 0; m < SEC_TICKS; m++) ms_step(m < w, m);
            if (s == 0) check_prev();
        end
        pend_acc = acc;
        pend_f   = nf;
        pend_tag = tag;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        tfields_t f;
        logic [58:0] b;
        void'($urandom(32'h5EED_0042));
        exp_f = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk({minute_bcd, hour_bcd, mday_bcd, wday, month_bcd, year_bcd, flags} == '0, "R1 fields",
            {minute_bcd, hour_bcd, mday_bcd, wday, month_bcd, year_bcd, flags}, 0);
        chk(fresh == 1'b0, "R1 fresh", fresh, 0);
        for (int m = 0; m < 2 * SEC_TICKS; m++) ms_step(1'b0, m);  // silence: first mark, empty frame

        f = rand_fields(); send_frame(make_frame(f), 59, 10, 20, -1, 0, 1, f, "R5");
        f = rand_fields(); send_frame(make_frame(f), 59, 10, 20, -1, 0, 1, f, "R11");
        f = rand_fields(); b = make_frame(f); b[28] = ~b[28];
        send_frame(b, 59, 10, 20, -1, 0, 0, f, "R7 P1");
        f = rand_fields(); send_frame(make_frame(f), 59, 10, 20, -1, 0, 1, f, "R9");
        f = rand_fields(); b = make_frame(f); b[33] = ~b[33];
        send_frame(b, 59, 10, 20, -1, 0, 0, f, "R7 P2");
        f = rand_fields(); b = make_frame(f); b[40] = ~b[40];
        send_frame(b, 59, 10, 20, -1, 0, 0, f, "R7 P3");
        f = rand_fields(); b = make_frame(f); b[20] = 1'b0;
        send_frame(b, 59, 10, 20, -1, 0, 0, f, "R6");
        f = rand_fields(); send_frame(make_frame(f), 59, 10, 20, 5, 15, 0, f, "R4 w15");
        f = rand_fields(); send_frame(make_frame(f), 59, 10, 20, 30, 5, 0, f, "R4 w5");
        f = rand_fields(); send_frame(make_frame(f), 59, 10, 20, 45, 26, 0, f, "R4 w26");
        f = rand_fields(); send_frame(make_frame(f), 59, Z_MAX, O_MAX, -1, 0, 1, f, "R2 R3 upper");
        f = rand_fields(); send_frame(make_frame(f), 59, Z_MIN, O_MIN, -1, 0, 1, f, "R2 R3 lower");
        f = rand_fields(); send_frame(make_frame(f), 58, 10, 20, -1, 0, 0, f, "R8 short");
        f = rand_fields(); send_frame(make_frame(f), 59, 10, 20, -1, 0, 1, f, "R10 after reject");
        // flush: one pulse start closes the last frame
        for (int m = 0; m < SEC_TICKS; m++) ms_step(m < 10, m);
        check_prev();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule